// File: doc/BRIEF.md
# Collider bunch pattern generator

This block produces the bunch-crossing timing of one circular collider orbit. It runs from the system clock and, while enabled, issues a one-cycle crossing strobe once every `CLK_PER_BX` clocks. With each strobe it presents the crossing number and a flag that says whether that crossing slot holds a filled bunch or an empty one. Downstream trigger logic may accept a trigger only on a strobe whose flag is high.

The fill pattern is fixed in logic as a nested structure. A basic train is a run of filled slots followed by a few empty ones. Basic trains are grouped into short and long groups, and each group ends with its own gap. Groups form repeated segments, then a tail of short groups, and a final long gap closes the orbit. An orbit-start pulse marks crossing 0. A synchronous reset returns the generator to the first slot of the first train. The enable input freezes the block in place.

Top module: `bunch_pattern_gen`

## Requirements
- R1: An orbit has 3564 crossings. `bx_num` on successive strobes counts 0, 1, …, 3563 and then wraps to 0.
- R2: While `en` is high, `bx_strobe` is high for exactly one cycle in every 2 enabled cycles (default `CLK_PER_BX` = 2). It is never high on two adjacent cycles.
- R3: `bx_filled` is valid in the same cycle as `bx_strobe` and is low in every cycle without a strobe.
- R4: A basic train is 72 filled crossings followed by 8 empty crossings. For example, crossing 71 is filled, 72 to 79 are empty and 80 is filled.
- R5: A short group is 3 basic trains followed by 30 empty crossings (crossings 240 to 269 empty, 270 filled). A long group is 4 basic trains followed by 31 empty crossings (crossings 860 to 890 empty, 891 filled).
- R6: The orbit is three repeats of (short, short, long), then three short groups, then 81 empty crossings (3483 to 3563). Crossing 3444 is filled and 3445 is empty. An orbit holds 2808 filled and 756 empty crossings.
- R7: `orbit_start` is high together with the strobe of crossing 0, and at no other time.
- R8: While `rst` is high at a clock edge, all outputs go low and `bx_num` goes to 0. The first strobe after release comes on the second enabled edge and carries crossing 0 with `orbit_start`.
- R9: While `en` is low, no strobe is issued and the phase and crossing position hold. After `en` returns high, the next strobe carries the crossing that follows the last one issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Run enable; low freezes the generator |
| bx_strobe | output | 1 | One-cycle crossing strobe |
| bx_num | output | 12 | Crossing number, valid with the strobe |
| bx_filled | output | 1 | High when the strobed crossing holds a filled bunch |
| orbit_start | output | 1 | High with the strobe of crossing 0 |

## Verification
A wrong counter inside the pattern walker shows up as a wrong `bx_filled` value at the first train or gap boundary after the fault. That happens within one train (80 crossings, 160 clocks) for slot errors, and within one orbit for group or segment errors. The per-orbit totals of 2808 and 756 expose any miscount in the nesting by the next `orbit_start`. A fault in the crossing counter shows up at the next strobe as a break in the +1 sequence of `bx_num`, or as a misplaced `orbit_start`.

// File: rtl/bpg_pkg.sv
package bpg_pkg;
  localparam int ORBIT_DEF       = 3564;
  localparam int TRAIN_FILL_DEF  = 72;
  localparam int TRAIN_GAP_DEF   = 8;
  localparam int SHORT_TRAINS_DEF = 3;
  localparam int SHORT_GAP_DEF   = 30;
  localparam int LONG_TRAINS_DEF = 4;
  localparam int LONG_GAP_DEF    = 31;
  localparam int SEG_SHORTS_DEF  = 2;
  localparam int SEG_REPEATS_DEF = 3;
  localparam int TAIL_SHORTS_DEF = 3;
  localparam int END_GAP_DEF     = 81;
  localparam int CLK_PER_BX_DEF  = 2;

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  function automatic int orbit_len(input int tf, input int tg, input int st, input int sg,
                                   input int lt, input int lg, input int ss, input int sr,
                                   input int ts, input int eg);
    int shrt, lng;
    shrt = st * (tf + tg) + sg;
    lng  = lt * (tf + tg) + lg;
    return sr * (ss * shrt + lng) + ts * shrt + eg;
  endfunction
endpackage

// File: rtl/bpg_phase.sv
module bpg_phase #(
  parameter int DIV = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic en,
  output logic tick
);
  localparam int CW = (DIV > 2) ? $clog2(DIV) : 1;
  logic [CW-1:0] cnt_q;

  assign tick = en && (cnt_q == CW'(DIV - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (en) begin
      if (cnt_q == CW'(DIV - 1)) cnt_q <= '0;
      else                       cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/bpg_xing_counter.sv
module bpg_xing_counter #(
  parameter int ORBIT = 3564,
  parameter int NW    = 12
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          adv,
  output logic [NW-1:0] num
);
  logic [NW-1:0] num_q;
  assign num = num_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      num_q <= '0;
    end else if (adv) begin
      if (num_q == NW'(ORBIT - 1)) num_q <= '0;
      else                         num_q <= num_q + 1'b1;
    end
  end
endmodule

// File: rtl/bpg_fill_walker.sv
module bpg_fill_walker
  import bpg_pkg::*;
#(
  parameter int TRAIN_FILL   = TRAIN_FILL_DEF,
  parameter int TRAIN_GAP    = TRAIN_GAP_DEF,
  parameter int SHORT_TRAINS = SHORT_TRAINS_DEF,
  parameter int SHORT_GAP    = SHORT_GAP_DEF,
  parameter int LONG_TRAINS  = LONG_TRAINS_DEF,
  parameter int LONG_GAP     = LONG_GAP_DEF,
  parameter int SEG_SHORTS   = SEG_SHORTS_DEF,
  parameter int SEG_REPEATS  = SEG_REPEATS_DEF,
  parameter int TAIL_SHORTS  = TAIL_SHORTS_DEF,
  parameter int END_GAP      = END_GAP_DEF
) (
  input  logic clk,
  input  logic rst,
  input  logic adv,
  output logic filled
);
  localparam int TRAIN_LEN = TRAIN_FILL + TRAIN_GAP;
  localparam int RUN_MAX   = imax(imax(TRAIN_LEN, END_GAP), imax(SHORT_GAP, LONG_GAP));
  localparam int SW  = $clog2(RUN_MAX + 1);
  localparam int TW  = $clog2(imax(SHORT_TRAINS, LONG_TRAINS) + 1);
  localparam int GW  = $clog2(imax(SEG_SHORTS, TAIL_SHORTS) + 1);
  localparam int SGW = $clog2(SEG_REPEATS + 1);

  logic [SW-1:0]  slot_q;
  logic [TW-1:0]  train_q;
  logic [GW-1:0]  grp_q;
  logic [SGW-1:0] seg_q;
  logic           in_gap_q;
  logic           end_q;

  logic           tail, long_grp, last_grp, last_train;
  logic [SW-1:0]  gap_m1;

  always_comb begin
    tail       = (seg_q == SGW'(SEG_REPEATS));
    long_grp   = !tail && (grp_q == GW'(SEG_SHORTS));
    last_grp   = tail ? (grp_q == GW'(TAIL_SHORTS - 1)) : long_grp;
    last_train = long_grp ? (train_q == TW'(LONG_TRAINS - 1))
                          : (train_q == TW'(SHORT_TRAINS - 1));
    gap_m1     = long_grp ? SW'(LONG_GAP - 1) : SW'(SHORT_GAP - 1);
    filled     = !end_q && !in_gap_q && (slot_q < SW'(TRAIN_FILL));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      slot_q   <= '0;
      train_q  <= '0;
      grp_q    <= '0;
      seg_q    <= '0;
      in_gap_q <= 1'b0;
      end_q    <= 1'b0;
    end else if (adv) begin
      if (end_q) begin
        if (slot_q == SW'(END_GAP - 1)) begin
          slot_q <= '0;
          seg_q  <= '0;
          grp_q  <= '0;
          end_q  <= 1'b0;
        end else begin
          slot_q <= slot_q + 1'b1;
        end
      end else if (!in_gap_q) begin
        if (slot_q == SW'(TRAIN_LEN - 1)) begin
          slot_q <= '0;
          if (last_train) begin
            train_q  <= '0;
            in_gap_q <= 1'b1;
          end else begin
            train_q <= train_q + 1'b1;
          end
        end else begin
          slot_q <= slot_q + 1'b1;
        end
      end else begin
        if (slot_q == gap_m1) begin
          slot_q   <= '0;
          in_gap_q <= 1'b0;
          if (last_grp) begin
            grp_q <= '0;
            if (tail) end_q <= 1'b1;
            else      seg_q <= seg_q + 1'b1;
          end else begin
            grp_q <= grp_q + 1'b1;
          end
        end else begin
          slot_q <= slot_q + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/bunch_pattern_gen.sv
module bunch_pattern_gen
  import bpg_pkg::*;
#(
  parameter int TRAIN_FILL   = TRAIN_FILL_DEF,
  parameter int TRAIN_GAP    = TRAIN_GAP_DEF,
  parameter int SHORT_TRAINS = SHORT_TRAINS_DEF,
  parameter int SHORT_GAP    = SHORT_GAP_DEF,
  parameter int LONG_TRAINS  = LONG_TRAINS_DEF,
  parameter int LONG_GAP     = LONG_GAP_DEF,
  parameter int SEG_SHORTS   = SEG_SHORTS_DEF,
  parameter int SEG_REPEATS  = SEG_REPEATS_DEF,
  parameter int TAIL_SHORTS  = TAIL_SHORTS_DEF,
  parameter int END_GAP      = END_GAP_DEF,
  parameter int CLK_PER_BX   = CLK_PER_BX_DEF,
  parameter int ORBIT = orbit_len(TRAIN_FILL, TRAIN_GAP, SHORT_TRAINS, SHORT_GAP, LONG_TRAINS,
                                  LONG_GAP, SEG_SHORTS, SEG_REPEATS, TAIL_SHORTS, END_GAP),
  parameter int NW    = $clog2(ORBIT)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          en,
  output logic          bx_strobe,
  output logic [NW-1:0] bx_num,
  output logic          bx_filled,
  output logic          orbit_start
);
  logic          tick;
  logic          slot_full;
  logic [NW-1:0] cur_num;

  bpg_phase #(.DIV(CLK_PER_BX)) u_phase (
    .clk(clk), .rst(rst), .en(en), .tick(tick)
  );

  bpg_xing_counter #(.ORBIT(ORBIT), .NW(NW)) u_xing (
    .clk(clk), .rst(rst), .adv(tick), .num(cur_num)
  );

  bpg_fill_walker #(
    .TRAIN_FILL(TRAIN_FILL), .TRAIN_GAP(TRAIN_GAP),
    .SHORT_TRAINS(SHORT_TRAINS), .SHORT_GAP(SHORT_GAP),
    .LONG_TRAINS(LONG_TRAINS), .LONG_GAP(LONG_GAP),
    .SEG_SHORTS(SEG_SHORTS), .SEG_REPEATS(SEG_REPEATS),
    .TAIL_SHORTS(TAIL_SHORTS), .END_GAP(END_GAP)
  ) u_walk (
    .clk(clk), .rst(rst), .adv(tick), .filled(slot_full)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      bx_strobe   <= 1'b0;
      bx_num      <= '0;
      bx_filled   <= 1'b0;
      orbit_start <= 1'b0;
    end else begin
      bx_strobe <= tick;
      if (tick) begin
        bx_num      <= cur_num;
        bx_filled   <= slot_full;
        orbit_start <= (cur_num == '0);
      end else begin
        bx_filled   <= 1'b0;
        orbit_start <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/bpg_checker.sv
module bpg_checker #(
  parameter int ORBIT  = 3564,
  parameter int NW     = 12,
  parameter int FILLED = 2808
) (
  input logic          clk,
  input logic          rst,
  input logic          en,
  input logic          bx_strobe,
  input logic [NW-1:0] bx_num,
  input logic          bx_filled,
  input logic          orbit_start
);
  logic [NW-1:0] last_num;
  logic          have_last;
  logic [NW:0]   fill_cnt;
  logic          seen_start;

  always_ff @(posedge clk) begin
    if (rst) begin
      last_num   <= '0;
      have_last  <= 1'b0;
      fill_cnt   <= '0;
      seen_start <= 1'b0;
    end else if (bx_strobe) begin
      last_num  <= bx_num;
      have_last <= 1'b1;
      if (orbit_start) begin
        seen_start <= 1'b1;
        fill_cnt   <= (NW+1)'(bx_filled);
      end else if (bx_filled) begin
        fill_cnt <= fill_cnt + 1'b1;
      end
    end
  end

  assert_num_range_R1: assert property (@(posedge clk) disable iff (rst)
    bx_strobe |-> (bx_num < NW'(ORBIT)));

  assert_num_step_R1: assert property (@(posedge clk) disable iff (rst)
    (bx_strobe && have_last) |->
      (bx_num == ((last_num == NW'(ORBIT - 1)) ? '0 : last_num + 1'b1)));

  assert_strobe_width_R2: assert property (@(posedge clk) disable iff (rst)
    bx_strobe |=> !bx_strobe);

  assert_flag_with_strobe_R3: assert property (@(posedge clk) disable iff (rst)
    bx_filled |-> bx_strobe);

  assert_orbit_total_R6: assert property (@(posedge clk) disable iff (rst)
    (bx_strobe && orbit_start && seen_start) |-> (fill_cnt == (NW+1)'(FILLED)));

  assert_start_only_zero_R7: assert property (@(posedge clk) disable iff (rst)
    orbit_start |-> (bx_strobe && bx_num == '0));

  assert_start_on_zero_R7: assert property (@(posedge clk) disable iff (rst)
    (bx_strobe && bx_num == '0) |-> orbit_start);

  assert_reset_quiet_R8: assert property (@(posedge clk)
    rst |=> (!bx_strobe && bx_num == '0 && !orbit_start));

  assert_hold_when_off_R9: assert property (@(posedge clk) disable iff (rst)
    !en |=> !bx_strobe);
endmodule

bind bunch_pattern_gen bpg_checker #(.ORBIT(ORBIT), .NW(NW)) u_bpg_checker (
  .clk(clk), .rst(rst), .en(en), .bx_strobe(bx_strobe), .bx_num(bx_num),
  .bx_filled(bx_filled), .orbit_start(orbit_start)
);

// File: tb/test_bunch_pattern_gen.sv
module test_bunch_pattern_gen;
  localparam int ORBIT = 3564;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        en  = 1'b0;
  logic        bx_strobe, bx_filled, orbit_start;
  logic [11:0] bx_num;

  int total = 0;
  int bad   = 0;
  int cycles = 0;

  bit pat [ORBIT];
  bit obs [ORBIT];

  int m_ph = 0, m_idx = 0;
  bit e_strobe = 0, e_fill = 0, e_start = 0;
  int e_num = 0;

  int orbit_seen = 0, n_fill = 0, n_empty = 0;
  int got_fill = -1, got_empty = -1;

  always #2 clk = ~clk;

  bunch_pattern_gen i_bunch_pattern_gen (
    .clk(clk), .rst(rst), .en(en), .bx_strobe(bx_strobe), .bx_num(bx_num),
    .bx_filled(bx_filled), .orbit_start(orbit_start)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic void build_pattern();
    int p = 0;
    int seg_groups [$];
    for (int s = 0; s < 3; s++) begin
      seg_groups.push_back(3); seg_groups.push_back(3); seg_groups.push_back(4);
    end
    for (int s = 0; s < 3; s++) seg_groups.push_back(3);
    foreach (seg_groups[g]) begin
      for (int t = 0; t < seg_groups[g]; t++) begin
        for (int k = 0; k < 80; k++) begin pat[p] = (k < 72); p++; end
      end
      for (int k = 0; k < ((seg_groups[g] == 4) ? 31 : 30); k++) begin pat[p] = 0; p++; end
    end
    for (int k = 0; k < 81; k++) begin pat[p] = 0; p++; end
  endfunction

  // behavioural reference: expected registered outputs
  always @(posedge clk) begin
    if (rst) begin
      m_ph <= 0; m_idx <= 0; e_strobe <= 0; e_fill <= 0; e_start <= 0; e_num <= 0;
    end else if (en && m_ph == 1) begin
      m_ph <= 0;
      e_strobe <= 1; e_num <= m_idx; e_fill <= pat[m_idx]; e_start <= (m_idx == 0);
      m_idx <= (m_idx + 1) % ORBIT;
    end else begin
      if (en) m_ph <= m_ph + 1;
      e_strobe <= 0; e_fill <= 0; e_start <= 0;
    end
  end

  // compare every clock, away from the active edge
  always @(negedge clk) begin
    cycles++;
    if (!rst) begin
      check(bx_strobe == e_strobe, "R2 strobe", bx_strobe, e_strobe);
      check(bx_filled == e_fill, "R3 flag", bx_filled, e_fill);
      check(orbit_start == e_start, "R7 orbit_start", orbit_start, e_start);
      if (e_strobe) check(bx_num == 12'(e_num), "R1 bx_num", bx_num, e_num);
      if (bx_strobe) begin
        if (orbit_start) begin
          if (orbit_seen > 0 && got_fill < 0) begin got_fill = n_fill; got_empty = n_empty; end
          orbit_seen++; n_fill = 0; n_empty = 0;
        end
        if (bx_filled) n_fill++; else n_empty++;
        if (orbit_seen == 1) obs[bx_num] = bx_filled;
      end
    end
    if (cycles > 100000) begin
      bad++; total++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 100000);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int last;
    build_pattern();
    repeat (3) @(negedge clk);
    en = 1;
    @(negedge clk);
    // R8 reset state
    check(!bx_strobe && bx_num == 0 && !bx_filled && !orbit_start, "R8 reset outputs",
          {bx_strobe, bx_filled, orbit_start}, 0);
    rst = 0;
    @(negedge clk);
    check(bx_strobe == 0, "R8 no strobe on first edge", bx_strobe, 0);
    @(negedge clk);
    check(bx_strobe && bx_num == 0 && orbit_start, "R8 first strobe is crossing 0", bx_num, 0);

    // run one full orbit and into the next
    repeat (2 * ORBIT + 4) @(negedge clk);
    check(got_fill == 2808, "R6 filled per orbit", got_fill, 2808);
    check(got_empty == 756, "R6 empty per orbit", got_empty, 756);
    check(obs[71] == 1 && obs[72] == 0, "R4 train edge 71/72", {obs[71], obs[72]}, 2);
    check(obs[79] == 0 && obs[80] == 1, "R4 train edge 79/80", {obs[79], obs[80]}, 1);
    check(obs[239] == 0 && obs[269] == 0 && obs[270] == 1, "R5 short gap",
          {obs[239], obs[269], obs[270]}, 1);
    check(obs[860] == 0 && obs[890] == 0 && obs[891] == 1 && obs[851] == 1, "R5 long gap",
          {obs[851], obs[860], obs[890], obs[891]}, 9);
    check(obs[3444] == 1 && obs[3445] == 0, "R6 last train end", {obs[3444], obs[3445]}, 2);
    begin
      int z = 0;
      for (int k = 3483; k < ORBIT; k++) if (obs[k]) z++;
      check(z == 0, "R6 final gap empty", z, 0);
    end

    // R9 pause: remember last crossing, hold enable low
    while (!bx_strobe) @(negedge clk);
    last = bx_num;
    en = 0;
    repeat (7) begin
      @(negedge clk);
      check(!bx_strobe, "R9 no strobe while disabled", bx_strobe, 0);
    end
    en = 1;
    while (!bx_strobe) @(negedge clk);
    check(bx_num == 12'((last + 1) % ORBIT), "R9 resume position", bx_num, (last + 1) % ORBIT);

    // R8 mid-run reset
    repeat (501) @(negedge clk);
    rst = 1;
    repeat (2) @(negedge clk);
    check(!bx_strobe && bx_num == 0 && !orbit_start, "R8 mid-run reset", bx_num, 0);
    rst = 0;
    @(negedge clk);
    check(!bx_strobe, "R8 phase cleared", bx_strobe, 0);
    @(negedge clk);
    check(bx_strobe && bx_num == 0 && orbit_start && bx_filled, "R8 restart at crossing 0",
          bx_num, 0);
    repeat (400) @(negedge clk);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule